// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block keeps the current address and the remaining element counts of one DMA channel. Each accepted data beat advances it by one element. A start pulse loads the address and counts from the configuration inputs and sets the channel running. Every beat that the bus side accepts while the channel runs then moves the address by a signed column stride and lowers the column count. Elements are bytes, halfwords or words.

When a row ends, the block can raise a one-cycle interrupt pulse. What happens next depends on the mode. In two-dimensional mode with rows left, it opens the next row. Otherwise a stop-mode channel finishes and pulses done. In every other flow mode it pulses a reload request and restarts from the configuration inputs, which the surrounding descriptor logic is expected to have refreshed.

On the last element of a row in two-dimensional mode, the column stride is not applied. The next row begins at the last element's address plus the row stride. The block drives no bus transfers itself. It only produces the address and counts that a transfer engine consumes.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the address, both counts and every flag and pulse output are zero, and the channel is not running.
- R2: The element size follows `cfg_width`: 2'b10 gives 4 bytes, 2'b01 gives 2 bytes, and 2'b00 or 2'b11 give 1 byte. At a start, `align_err` is set exactly when `start_addr` is not a multiple of the element size. The channel still starts.
- R3: At a start, `stride_err` is set exactly when the magnitude of the signed `x_modify` differs from the element size. In that case the channel does not start running.
- R4: A start pulse loads `cur_addr` from `start_addr`, `cur_x` from `x_count` and `cur_y` from `y_count`. A count of zero loads as 16'hFFFF. A start pulse takes priority over a beat in the same cycle.
- R5: A beat on an element that is not the last of its row (`cur_x` greater than 1) adds the sign-extended `x_modify` to `cur_addr` and decrements `cur_x`. The new values appear after the clock edge that samples the beat.
- R6: When `beat_ok` is low, or the channel is not running, the address and counts do not change.
- R7: A beat on the last element of a row (`cur_x` equal to 1) produces a one-cycle `row_irq` pulse if `cfg_irq_en` is set, and no pulse if it is clear.
- R8: In two-dimensional mode (`cfg_2d` = 1), a row end with `cur_y` above 1 does three things. It decrements `cur_y`, reloads `cur_x` from `x_count`, and sets `cur_addr` to its value plus the sign-extended `y_modify`, without applying `x_modify`. The channel keeps running.
- R9: In stop flow (`cfg_flow` = 2'b00), a row end with no rows left adds `x_modify` to the address and clears `cur_x`. It stops the channel and produces a one-cycle `done` pulse.
- R10: In any other flow (`cfg_flow` of 2'b01, 2'b10 or 2'b11), a row end with no rows left produces a one-cycle `reload_req` pulse. It reloads address and counts as a start does, and the channel keeps running. `done` stays low.
- R11: In one-dimensional mode (`cfg_2d` = 0), every row end counts as having no rows left, whatever `cur_y` holds, and `cur_y` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load address and counts, begin running |
| beat_ok | input | 1 | One element accepted by the bus side this cycle |
| cfg_width | input | 2 | Element size code |
| cfg_2d | input | 1 | Enable second dimension |
| cfg_irq_en | input | 1 | Pulse `row_irq` at each row end |
| cfg_flow | input | 2 | Flow mode, 2'b00 is stop |
| start_addr | input | 32 | First element address |
| x_count | input | 16 | Elements per row |
| x_modify | input | 16 | Signed stride between elements |
| y_count | input | 16 | Number of rows |
| y_modify | input | 16 | Signed stride from last element of a row to first of the next |
| cur_addr | output | 32 | Current element address |
| cur_x | output | 16 | Elements left in the current row |
| cur_y | output | 16 | Rows left |
| running | output | 1 | Channel active |
| row_irq | output | 1 | Row-end interrupt pulse |
| done | output | 1 | Channel-complete pulse |
| reload_req | output | 1 | Descriptor reload pulse |
| align_err | output | 1 | Start address misaligned for the element size |
| stride_err | output | 1 | Column stride magnitude unsupported |

## Verification
The hardest case to reach is a row end in two-dimensional mode with a negative column stride. In that case the missing column step on the last element is visible in the address, while the row counter decides between starting a row and finishing. The stimulus loads a two-row, two-element halfword transfer with a stride of minus two, then walks it beat by beat. The bench checks the exact address after each row change and at completion. Beats with `beat_ok` low are mixed in mid-row, and beats are also sent after completion, to show the state holds.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        FLOW_STOP  = 2'b00,
        FLOW_AUTO  = 2'b01,
        FLOW_DESCA = 2'b10,
        FLOW_DESCB = 2'b11
    } flow_e;

    typedef enum logic [1:0] {
        WID_BYTE  = 2'b00,
        WID_HALF  = 2'b01,
        WID_WORD  = 2'b10,
        WID_BYTE2 = 2'b11
    } width_e;

    localparam int ESZ_W = 3;

endpackage

// File: rtl/dma2d_cfg_check.sv
module dma2d_cfg_check
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [1:0]       cfg_width,
    input  logic [AW-1:0]    start_addr,
    input  logic [CW-1:0]    x_modify,
    output logic [ESZ_W-1:0] elem_bytes,
    output logic             misaligned,
    output logic             stride_bad
);
    logic [ESZ_W-1:0] mask_c;
    logic [CW-1:0]    mag_c;

    always_comb begin
        unique case (width_e'(cfg_width))
            WID_WORD: elem_bytes = ESZ_W'(4);
            WID_HALF: elem_bytes = ESZ_W'(2);
            default:  elem_bytes = ESZ_W'(1);
        endcase
        mask_c     = elem_bytes - ESZ_W'(1);
        misaligned = |(start_addr[ESZ_W-1:0] & mask_c);
        mag_c      = x_modify[CW-1] ? (~x_modify + CW'(1)) : x_modify;
        stride_bad = (mag_c != CW'(elem_bytes));
    end

endmodule

// File: rtl/dma2d_step_core.sv
module dma2d_step_core
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          beat_ok,
    input  logic          cfg_2d,
    input  logic          cfg_irq_en,
    input  logic [1:0]    cfg_flow,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] x_count,
    input  logic [CW-1:0] x_modify,
    input  logic [CW-1:0] y_count,
    input  logic [CW-1:0] y_modify,
    input  logic          misaligned,
    input  logic          stride_bad,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic          running,
    output logic          row_irq,
    output logic          done,
    output logic          reload_req,
    output logic          align_err,
    output logic          stride_err
);
    localparam int            EXT_W = AW - CW;
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          run;
        logic          irq;
        logic          done;
        logic          reload;
        logic          aerr;
        logic          serr;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] xstep_c, ystep_c;
    logic [CW-1:0] ldx_c, ldy_c;
    logic          more_rows_c;

    always_comb begin
        xstep_c     = {{EXT_W{x_modify[CW-1]}}, x_modify};
        ystep_c     = {{EXT_W{y_modify[CW-1]}}, y_modify};
        ldx_c       = (x_count == '0) ? '1 : x_count;
        ldy_c       = (y_count == '0) ? '1 : y_count;
        more_rows_c = cfg_2d && (st_q.y > ONE_C);

        st_d        = st_q;
        st_d.irq    = 1'b0;
        st_d.done   = 1'b0;
        st_d.reload = 1'b0;

        if (start) begin
            st_d.addr = start_addr;
            st_d.x    = ldx_c;
            st_d.y    = ldy_c;
            st_d.aerr = misaligned;
            st_d.serr = stride_bad;
            st_d.run  = !stride_bad;
        end else if (beat_ok && st_q.run) begin
            if (st_q.x > ONE_C) begin
                st_d.addr = st_q.addr + xstep_c;
                st_d.x    = st_q.x - ONE_C;
            end else begin
                st_d.irq = cfg_irq_en;
                if (more_rows_c) begin
                    st_d.y    = st_q.y - ONE_C;
                    st_d.x    = ldx_c;
                    st_d.addr = st_q.addr + ystep_c;
                end else if (flow_e'(cfg_flow) == FLOW_STOP) begin
                    st_d.addr = st_q.addr + xstep_c;
                    st_d.x    = '0;
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.reload = 1'b1;
                    st_d.addr   = start_addr;
                    st_d.x      = ldx_c;
                    st_d.y      = ldy_c;
                    st_d.aerr   = misaligned;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr   = st_q.addr;
    assign cur_x      = st_q.x;
    assign cur_y      = st_q.y;
    assign running    = st_q.run;
    assign row_irq    = st_q.irq;
    assign done       = st_q.done;
    assign reload_req = st_q.reload;
    assign align_err  = st_q.aerr;
    assign stride_err = st_q.serr;

    p_live_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.x != '0));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(beat_ok && st_q.run)) |=>
            ($stable(st_q.addr) && $stable(st_q.x) && $stable(st_q.y)));

    p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.x > ONE_C && !start) |=> !st_q.irq);

    p_done_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.run && st_q.x == '0));

    p_end_kinds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.done, st_q.reload}));

    p_badstride_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && stride_bad) |=> !st_q.run);

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          beat_ok,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_2d,
    input  logic          cfg_irq_en,
    input  logic [1:0]    cfg_flow,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] x_count,
    input  logic [CW-1:0] x_modify,
    input  logic [CW-1:0] y_count,
    input  logic [CW-1:0] y_modify,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic          running,
    output logic          row_irq,
    output logic          done,
    output logic          reload_req,
    output logic          align_err,
    output logic          stride_err
);
    logic [ESZ_W-1:0] elem_bytes_w;
    logic             misaligned_w;
    logic             stride_bad_w;

    dma2d_cfg_check #(.AW(AW), .CW(CW)) u_check (
        .cfg_width  (cfg_width),
        .start_addr (start_addr),
        .x_modify   (x_modify),
        .elem_bytes (elem_bytes_w),
        .misaligned (misaligned_w),
        .stride_bad (stride_bad_w)
    );

    dma2d_step_core #(.AW(AW), .CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .beat_ok    (beat_ok),
        .cfg_2d     (cfg_2d),
        .cfg_irq_en (cfg_irq_en),
        .cfg_flow   (cfg_flow),
        .start_addr (start_addr),
        .x_count    (x_count),
        .x_modify   (x_modify),
        .y_count    (y_count),
        .y_modify   (y_modify),
        .misaligned (misaligned_w),
        .stride_bad (stride_bad_w),
        .cur_addr   (cur_addr),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .running    (running),
        .row_irq    (row_irq),
        .done       (done),
        .reload_req (reload_req),
        .align_err  (align_err),
        .stride_err (stride_err)
    );

    p_elem_pow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(elem_bytes_w));

endmodule

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        beat_ok = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_2d = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic [1:0]  cfg_flow = 2'b00;
    logic [31:0] start_addr = '0;
    logic [15:0] x_count = '0;
    logic [15:0] x_modify = '0;
    logic [15:0] y_count = '0;
    logic [15:0] y_modify = '0;
    logic [31:0] cur_addr;
    logic [15:0] cur_x, cur_y;
    logic        running, row_irq, done, reload_req, align_err, stride_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    dma2d_addr_gen u_dma2d_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .beat_ok(beat_ok),
        .cfg_width(cfg_width), .cfg_2d(cfg_2d), .cfg_irq_en(cfg_irq_en),
        .cfg_flow(cfg_flow), .start_addr(start_addr), .x_count(x_count),
        .x_modify(x_modify), .y_count(y_count), .y_modify(y_modify),
        .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y), .running(running),
        .row_irq(row_irq), .done(done), .reload_req(reload_req),
        .align_err(align_err), .stride_err(stride_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic beat(input logic b);
        beat_ok = b;
        tick();
        beat_ok = 1'b0;
    endtask

    task automatic setup(input logic [1:0] w, input logic d2, input logic ie,
                         input logic [1:0] fl, input logic [31:0] sa,
                         input logic [15:0] xc, input logic [15:0] xm,
                         input logic [15:0] yc, input logic [15:0] ym);
        cfg_width = w; cfg_2d = d2; cfg_irq_en = ie; cfg_flow = fl;
        start_addr = sa; x_count = xc; x_modify = xm; y_count = yc; y_modify = ym;
    endtask

    task automatic t_reset();
        chk("R1", "addr", cur_addr, 32'h0);
        chk("R1", "x/y", {cur_x, cur_y}, 32'h0);
        chk("R1", "flags", {26'h0, running, row_irq, done, reload_req, align_err, stride_err}, 32'h0);
    endtask

    task automatic t_one_dim_stop();
        setup(2'b10, 1'b0, 1'b1, 2'b00, 32'h100, 16'd3, 16'd4, 16'd5, 16'd0);
        do_start();
        chk("R4", "load addr", cur_addr, 32'h100);
        chk("R4", "load x/y", {cur_x, cur_y}, {16'd3, 16'd5});
        chk("R4", "running", running, 1'b1);
        beat(1'b1);
        chk("R5", "addr step", cur_addr, 32'h104);
        chk("R5", "x step", cur_x, 16'd2);
        beat(1'b0);
        beat(1'b0);
        chk("R6", "hold addr", cur_addr, 32'h104);
        chk("R6", "hold x", cur_x, 16'd2);
        beat(1'b1);
        chk("R5", "addr step2", cur_addr, 32'h108);
        chk("R7", "no irq mid-row", row_irq, 1'b0);
        beat(1'b1);
        chk("R9", "final addr", cur_addr, 32'h10C);
        chk("R9", "x cleared", cur_x, 16'd0);
        chk("R9", "stopped", running, 1'b0);
        chk("R9", "done pulse", done, 1'b1);
        chk("R7", "irq pulse", row_irq, 1'b1);
        chk("R11", "y untouched", cur_y, 16'd5);
        chk("R10", "no reload in stop", reload_req, 1'b0);
        beat(1'b1);
        chk("R9", "done one cycle", done, 1'b0);
        chk("R7", "irq one cycle", row_irq, 1'b0);
        chk("R6", "idle hold addr", cur_addr, 32'h10C);
    endtask

    task automatic t_two_dim_neg();
        setup(2'b01, 1'b1, 1'b1, 2'b00, 32'h200, 16'd2, 16'hFFFE, 16'd2, 16'h0020);
        do_start();
        chk("R2", "aligned half", align_err, 1'b0);
        beat(1'b1);
        chk("R5", "neg stride", cur_addr, 32'h1FE);
        beat(1'b1);
        chk("R8", "row addr", cur_addr, 32'h21E);
        chk("R8", "x reload / y dec", {cur_x, cur_y}, {16'd2, 16'd1});
        chk("R8", "still running", running, 1'b1);
        chk("R7", "irq at row end", row_irq, 1'b1);
        chk("R8", "no done", done, 1'b0);
        beat(1'b1);
        chk("R5", "row2 step", cur_addr, 32'h21C);
        beat(1'b1);
        chk("R9", "2D final addr", cur_addr, 32'h21A);
        chk("R9", "2D done", {running, done}, 2'b01);
    endtask

    task automatic t_irq_off();
        setup(2'b00, 1'b0, 1'b0, 2'b00, 32'h40, 16'd1, 16'd1, 16'd1, 16'd0);
        do_start();
        beat(1'b1);
        chk("R7", "irq disabled", row_irq, 1'b0);
        chk("R9", "done single", done, 1'b1);
    endtask

    task automatic t_reload();
        setup(2'b00, 1'b0, 1'b1, 2'b01, 32'h33, 16'd2, 16'd1, 16'd7, 16'd0);
        do_start();
        beat(1'b1);
        chk("R5", "byte step", cur_addr, 32'h34);
        beat(1'b1);
        chk("R10", "reload pulse", reload_req, 1'b1);
        chk("R10", "addr reloaded", cur_addr, 32'h33);
        chk("R10", "counts reloaded", {cur_x, cur_y}, {16'd2, 16'd7});
        chk("R10", "keeps running", {running, done}, 2'b10);
        beat(1'b0);
        chk("R10", "reload one cycle", reload_req, 1'b0);
    endtask

    task automatic t_align();
        setup(2'b10, 1'b0, 1'b0, 2'b00, 32'h102, 16'd2, 16'd4, 16'd1, 16'd0);
        do_start();
        chk("R2", "word misaligned", {align_err, running}, 2'b11);
        start_addr = 32'h104;
        do_start();
        chk("R2", "word aligned clears", align_err, 1'b0);
        setup(2'b01, 1'b0, 1'b0, 2'b00, 32'h101, 16'd2, 16'd2, 16'd1, 16'd0);
        do_start();
        chk("R2", "half misaligned", align_err, 1'b1);
        setup(2'b11, 1'b0, 1'b0, 2'b00, 32'h103, 16'd2, 16'd1, 16'd1, 16'd0);
        do_start();
        chk("R2", "code 3 is byte", {align_err, stride_err, running}, 3'b001);
    endtask

    task automatic t_stride();
        setup(2'b10, 1'b0, 1'b0, 2'b00, 32'h80, 16'd4, 16'd2, 16'd1, 16'd0);
        do_start();
        chk("R3", "bad stride flagged", {stride_err, running}, 2'b10);
        beat(1'b1);
        chk("R6", "no step when stopped", cur_addr, 32'h80);
        setup(2'b00, 1'b0, 1'b0, 2'b00, 32'h80, 16'd4, 16'hFFFF, 16'd1, 16'd0);
        do_start();
        chk("R3", "neg byte stride ok", {stride_err, running}, 2'b01);
    endtask

    task automatic t_zero_count();
        setup(2'b00, 1'b1, 1'b0, 2'b00, 32'h10, 16'd0, 16'd1, 16'd0, 16'd0);
        do_start();
        chk("R4", "zero counts", {cur_x, cur_y}, 32'hFFFF_FFFF);
        start = 1'b1; beat_ok = 1'b1;
        start_addr = 32'h20;
        tick();
        start = 1'b0; beat_ok = 1'b0;
        chk("R4", "start beats beat", cur_addr, 32'h20);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_one_dim_stop();
        t_two_dim_neg();
        t_irq_off();
        t_reload();
        t_align();
        t_stride();
        t_zero_count();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule